// File: doc/BRIEF.md
# Ethernet Controller Event Status and Interrupt Register Block

This block sits between the network-side logic of a simple Ethernet controller and the host. Single-cycle event pulses from the transmit path, the receive path and the buffer DMA engine are caught in sticky status bits. The host reads those bits through a byte-wide register port and clears them by writing ones back to the same offset. A mask register for each direction chooses which latched events may raise the interrupt line. A read-only summary byte combines, in one read, active-low pending-interrupt indications with active-high busy flags from the buffer logic.

The transmit mode register holds four host-writable control bits in its low nibble. Its high nibble is a read-only count of collisions since the last successful send. The count is driven from the collision and sent-OK transmit events. Reads are registered: a read strobe captures the addressed register, and the value appears on the read data bus one cycle later and stays there until the next read strobe.

Top module: `nic_irq_regs`

## Requirements
- R1: A 1 on any bit of `tx_evt` for one cycle sets the matching bit of the transmit status register (offset 0x00). The bit stays set until the host clears it. Bit meanings: 7 sent OK, 6 carrier sense, 5 own frame seen, 4 medium shorted, 3 underflow, 2 collision, 1 sixteenth collision, 0 parity error.
- R2: A 1 on `rx_evt` bits 7, 4, 3, 2, 1 or 0 sets the matching bit of the receive status register (offset 0x02). Those bits mean good frame, reset frame, runt, alignment, CRC and overflow. Bits 6 and 5 are never set and always read 0.
- R3: A write to offset 0x00 or 0x02 clears each status bit whose write data bit is 1. Status bits written with 0 are left unchanged.
- R4: If an event pulse and a clearing write reach the same status bit in the same cycle, the bit ends up set.
- R5: The transmit mask (0x01) and receive mask (0x03) read back the last value written. Receive mask bits 6 and 5 always read 0.
- R6: `irq` is 1 exactly when some transmit status bit is set with its mask bit, or some receive status bit is set with its mask bit, or a DMA-done event is pending. It changes in the same cycle as the state that drives it.
- R7: The summary byte at 0x13 reads as follows. Bit 0 is 0 when an unmasked transmit event is pending, and bit 1 is 0 when an unmasked receive event is pending. Bit 2 is 0 when DMA-done is pending. Bit 5 follows `rx_armed`, bit 4 follows `tx_busy` and bit 3 follows `dma_busy`. Bits 7 and 6 read 0. Writes do not change the masks or status.
- R8: `dma_done_evt` sets the DMA-done pending flag. Any write to 0x13 clears it, but an event arriving in the same cycle as that write keeps it set.
- R9: Offset 0x04 reads the collision count in bits 7:4 and the control nibble in bits 3:0. Writing sets only bits 3:0, and those bits drive `tx_mode_ctl`. The count rises by one on each collision event (`tx_evt` bit 2) and stops at 15. A sent-OK event (`tx_evt` bit 7) returns it to 0, and takes precedence over a collision in the same cycle.
- R10: After reset, every status bit, mask bit, pending flag, control bit and the collision count are 0.
- R11: `reg_rdata` takes the addressed register's value at the edge where `reg_rd` is 1, and holds it otherwise. Offsets with no register read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 5 | Register offset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| tx_evt | input | 8 | Transmit event pulses, one per status bit |
| rx_evt | input | 8 | Receive event pulses, one per status bit |
| dma_done_evt | input | 1 | DMA completion pulse |
| rx_armed | input | 1 | Reception enabled, no frame completed yet |
| tx_busy | input | 1 | Transmit in progress |
| dma_busy | input | 1 | DMA transfer active |
| tx_mode_ctl | output | 4 | Host-written transmit control nibble |
| irq | output | 1 | Interrupt request, active high |

## Verification
Status bits, masks, the pending DMA flag and the collision count change at the clock edge that takes the event or write. `irq` follows from that state in the same cycle. A register read shows up on `reg_rdata` one edge after the read strobe. The bench drives every stimulus at a falling edge and removes it at the next falling edge, so exactly one rising edge acts on it. It checks `irq` at that second falling edge, and it reads registers with a strobe held across one rising edge and samples the data at the falling edge that follows.

// File: rtl/nic_irq_pkg.sv
package nic_irq_pkg;
  localparam int OFS_TXSTAT  = 'h00;
  localparam int OFS_TXMASK  = 'h01;
  localparam int OFS_RXSTAT  = 'h02;
  localparam int OFS_RXMASK  = 'h03;
  localparam int OFS_TXMODE  = 'h04;
  localparam int OFS_SUMMARY = 'h13;

  localparam logic [7:0] TX_VALID = 8'hFF;
  localparam logic [7:0] RX_VALID = 8'h9F;

  localparam int TXB_OK   = 7;
  localparam int TXB_COLL = 2;

  localparam int SUM_TX_N     = 0;
  localparam int SUM_RX_N     = 1;
  localparam int SUM_DMA_N    = 2;
  localparam int SUM_DMA_BUSY = 3;
  localparam int SUM_TX_BUSY  = 4;
  localparam int SUM_RX_ARMED = 5;
endpackage

// File: rtl/nic_evt_latch.sv
module nic_evt_latch #(
  parameter int          W     = 8,
  parameter logic [W-1:0] VALID = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic         clr_we,
  input  logic         mask_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] stat,
  output logic [W-1:0] mask,
  output logic         hit
);
  logic [W-1:0] stat_q;
  logic [W-1:0] mask_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (VALID[i]) begin : g_live
      logic s_q, s_d, s_en;
      logic m_q;

      always_comb begin
        s_en = evt[i] | (clr_we & wdata[i]);
        s_d  = s_q;
        if (clr_we && wdata[i]) s_d = 1'b0;
        if (evt[i])             s_d = 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    s_q <= 1'b0;
        else if (s_en) s_q <= s_d;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       m_q <= 1'b0;
        else if (mask_we) m_q <= wdata[i];
      end

      assign stat_q[i] = s_q;
      assign mask_q[i] = m_q;
    end else begin : g_dead
      assign stat_q[i] = 1'b0;
      assign mask_q[i] = 1'b0;
    end
  end

  logic unused_dead;
  assign unused_dead = ^((evt | wdata) & ~VALID);

  assign stat = stat_q;
  assign mask = mask_q;
  assign hit  = |(stat_q & mask_q);

  assert_evt_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt & VALID)) |=> ((stat & $past(evt & VALID)) == $past(evt & VALID)));

  assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && (evt == '0)) |=> ((stat & $past(wdata)) == '0));

  assert_mask_wr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> (mask == ($past(wdata) & VALID)));
endmodule

// File: rtl/nic_coll_count.sv
module nic_coll_count #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          coll,
  input  logic          sent_ok,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] CMAX = '1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = coll | sent_ok;
    if (sent_ok)           cnt_d = '0;
    else if (cnt_q == CMAX) cnt_d = CMAX;
    else                   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  assert_coll_sat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CMAX && coll && !sent_ok) |=> (cnt == CMAX));

  assert_coll_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sent_ok |=> (cnt == '0));

  assert_coll_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!coll && !sent_ok) |=> $stable(cnt));
endmodule

// File: rtl/nic_isr.sv
module nic_isr
  import nic_irq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_hit,
  input  logic          rx_hit,
  input  logic          dma_evt,
  input  logic          dma_clr_we,
  input  logic          rx_armed,
  input  logic          tx_busy,
  input  logic          dma_busy,
  output logic [DW-1:0] sum,
  output logic          dma_pend
);
  logic pend_q, pend_d, pend_en;

  always_comb begin
    pend_en = dma_evt | dma_clr_we;
    pend_d  = dma_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_d;
  end

  always_comb begin
    sum               = '0;
    sum[SUM_TX_N]     = ~tx_hit;
    sum[SUM_RX_N]     = ~rx_hit;
    sum[SUM_DMA_N]    = ~pend_q;
    sum[SUM_DMA_BUSY] = dma_busy;
    sum[SUM_TX_BUSY]  = tx_busy;
    sum[SUM_RX_ARMED] = rx_armed;
  end

  assign dma_pend = pend_q;

  assert_dma_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !dma_clr_we) |=> pend_q);

  assert_dma_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dma_evt |=> pend_q);
endmodule

// File: rtl/nic_irq_regs.sv
module nic_irq_regs
  import nic_irq_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 5,
  parameter int CW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    reg_addr,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic [DW-1:0]    tx_evt,
  input  logic [DW-1:0]    rx_evt,
  input  logic             dma_done_evt,
  input  logic             rx_armed,
  input  logic             tx_busy,
  input  logic             dma_busy,
  output logic [DW-CW-1:0] tx_mode_ctl,
  output logic             irq
);
  localparam int MW = DW - CW;

  logic sel_txstat, sel_txmask, sel_rxstat, sel_rxmask, sel_txmode, sel_sum;

  always_comb begin
    sel_txstat = (reg_addr == AW'(OFS_TXSTAT));
    sel_txmask = (reg_addr == AW'(OFS_TXMASK));
    sel_rxstat = (reg_addr == AW'(OFS_RXSTAT));
    sel_rxmask = (reg_addr == AW'(OFS_RXMASK));
    sel_txmode = (reg_addr == AW'(OFS_TXMODE));
    sel_sum    = (reg_addr == AW'(OFS_SUMMARY));
  end

  logic [DW-1:0] tx_stat, tx_mask, rx_stat, rx_mask, sum_byte;
  logic          tx_hit, rx_hit, dma_pend;
  logic [CW-1:0] coll_cnt;

  nic_evt_latch #(.W(DW), .VALID(DW'(TX_VALID))) u_tx_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (tx_evt),
    .clr_we  (reg_wr & sel_txstat),
    .mask_we (reg_wr & sel_txmask),
    .wdata   (reg_wdata),
    .stat    (tx_stat),
    .mask    (tx_mask),
    .hit     (tx_hit)
  );

  nic_evt_latch #(.W(DW), .VALID(DW'(RX_VALID))) u_rx_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (rx_evt),
    .clr_we  (reg_wr & sel_rxstat),
    .mask_we (reg_wr & sel_rxmask),
    .wdata   (reg_wdata),
    .stat    (rx_stat),
    .mask    (rx_mask),
    .hit     (rx_hit)
  );

  nic_coll_count #(.CW(CW)) u_coll (
    .clk     (clk),
    .rst_n   (rst_n),
    .coll    (tx_evt[TXB_COLL]),
    .sent_ok (tx_evt[TXB_OK]),
    .cnt     (coll_cnt)
  );

  nic_isr #(.DW(DW)) u_isr (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_hit     (tx_hit),
    .rx_hit     (rx_hit),
    .dma_evt    (dma_done_evt),
    .dma_clr_we (reg_wr & sel_sum),
    .rx_armed   (rx_armed),
    .tx_busy    (tx_busy),
    .dma_busy   (dma_busy),
    .sum        (sum_byte),
    .dma_pend   (dma_pend)
  );

  logic [MW-1:0] mode_q;
  logic          mode_en;

  always_comb mode_en = reg_wr & sel_txmode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (mode_en) mode_q <= reg_wdata[MW-1:0];
  end

  logic [DW-1:0] rd_mux, rdata_q;

  always_comb begin
    rd_mux = '0;
    if (sel_txstat) rd_mux = tx_stat;
    if (sel_txmask) rd_mux = tx_mask;
    if (sel_rxstat) rd_mux = rx_stat;
    if (sel_rxmask) rd_mux = rx_mask;
    if (sel_txmode) rd_mux = {coll_cnt, mode_q};
    if (sel_sum)    rd_mux = sum_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (reg_rd) rdata_q <= rd_mux;
  end

  assign reg_rdata   = rdata_q;
  assign tx_mode_ctl = mode_q;
  assign irq         = tx_hit | rx_hit | dma_pend;

  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata));

  assert_irq_dma_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dma_done_evt |=> irq);

  assert_mode_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && sel_txmode) |=> $stable(tx_mode_ctl));
endmodule

// File: tb/nic_irq_regs_tb.sv
module nic_irq_regs_tb;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [7:0] tx_evt = '0;
  logic [7:0] rx_evt = '0;
  logic       dma_done_evt = 1'b0;
  logic       rx_armed = 1'b0;
  logic       tx_busy = 1'b0;
  logic       dma_busy = 1'b0;
  logic [3:0] tx_mode_ctl;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  nic_irq_regs u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_evt(tx_evt), .rx_evt(rx_evt), .dma_done_evt(dma_done_evt),
    .rx_armed(rx_armed), .tx_busy(tx_busy), .dma_busy(dma_busy),
    .tx_mode_ctl(tx_mode_ctl), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic pulse(input logic [7:0] tx, input logic [7:0] rx, input logic dma);
    @(negedge clk); tx_evt = tx; rx_evt = rx; dma_done_evt = dma;
    @(negedge clk); tx_evt = '0; rx_evt = '0; dma_done_evt = 1'b0;
  endtask

  task automatic clear_all();
    wr(5'h00, 8'hFF); wr(5'h02, 8'hFF); wr(5'h13, 8'h00);
    wr(5'h01, 8'h00); wr(5'h03, 8'h00);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(5'h00, v); chk("R10 tx status", v, 8'h00);
    rd(5'h01, v); chk("R10 tx mask", v, 8'h00);
    rd(5'h02, v); chk("R10 rx status", v, 8'h00);
    rd(5'h03, v); chk("R10 rx mask", v, 8'h00);
    rd(5'h04, v); chk("R10 mode", v, 8'h00);
    rd(5'h13, v); chk("R10 summary", v, 8'h07);
    chk("R10 irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_latch();
    logic [7:0] v;
    pulse(8'h44, 8'h00, 1'b0);
    rd(5'h00, v); chk("R1 tx latch", v, 8'h44);
    pulse(8'h01, 8'h00, 1'b0);
    rd(5'h00, v); chk("R1 tx sticky", v, 8'h45);
    pulse(8'h00, 8'hFF, 1'b0);
    rd(5'h02, v); chk("R2 rx latch", v, 8'h9F);
  endtask

  task automatic t_w1c();
    logic [7:0] v;
    wr(5'h00, 8'h04);
    rd(5'h00, v); chk("R3 tx w1c", v, 8'h41);
    wr(5'h02, 8'h81);
    rd(5'h02, v); chk("R3 rx w1c", v, 8'h1E);
  endtask

  task automatic t_set_wins();
    logic [7:0] v;
    wr(5'h00, 8'hFF);
    @(negedge clk); reg_addr = 5'h00; reg_wdata = 8'h02; reg_wr = 1'b1; tx_evt = 8'h02;
    @(negedge clk); reg_wr = 1'b0; tx_evt = '0;
    rd(5'h00, v); chk("R4 set beats clear", v, 8'h02);
  endtask

  task automatic t_masks();
    logic [7:0] v;
    wr(5'h01, 8'hA5);
    rd(5'h01, v); chk("R5 tx mask", v, 8'hA5);
    wr(5'h03, 8'hFF);
    rd(5'h03, v); chk("R5 rx mask", v, 8'h9F);
  endtask

  task automatic t_irq();
    logic [7:0] v;
    clear_all();
    wr(5'h01, 8'h80);
    pulse(8'h04, 8'h00, 1'b0);
    chk("R6 masked no irq", {7'd0, irq}, 8'h00);
    rd(5'h13, v); chk("R7 masked summary", v, 8'h07);
    pulse(8'h80, 8'h00, 1'b0);
    chk("R6 tx irq", {7'd0, irq}, 8'h01);
    rd(5'h13, v); chk("R7 tx pending", v, 8'h06);
    wr(5'h00, 8'h80);
    chk("R6 irq drops", {7'd0, irq}, 8'h00);
    wr(5'h03, 8'h02);
    pulse(8'h00, 8'h02, 1'b0);
    chk("R6 rx irq", {7'd0, irq}, 8'h01);
    rd(5'h13, v); chk("R7 rx pending", v, 8'h05);
    wr(5'h13, 8'hFF);
    rd(5'h03, v); chk("R7 summary write inert", v, 8'h02);
    clear_all();
  endtask

  task automatic t_dma();
    logic [7:0] v;
    pulse(8'h00, 8'h00, 1'b1);
    chk("R6 dma irq", {7'd0, irq}, 8'h01);
    rd(5'h13, v); chk("R7 dma pending", v, 8'h03);
    wr(5'h13, 8'h00);
    chk("R8 dma cleared", {7'd0, irq}, 8'h00);
    @(negedge clk); reg_addr = 5'h13; reg_wr = 1'b1; dma_done_evt = 1'b1;
    @(negedge clk); reg_wr = 1'b0; dma_done_evt = 1'b0;
    chk("R8 dma set wins", {7'd0, irq}, 8'h01);
    wr(5'h13, 8'h00);
  endtask

  task automatic t_busy();
    logic [7:0] v;
    rx_armed = 1'b1; dma_busy = 1'b1;
    rd(5'h13, v); chk("R7 busy flags", v, 8'h2F);
    rx_armed = 1'b0; dma_busy = 1'b0; tx_busy = 1'b1;
    rd(5'h13, v); chk("R7 tx busy", v, 8'h17);
    tx_busy = 1'b0;
  endtask

  task automatic t_coll();
    logic [7:0] v;
    pulse(8'h80, 8'h00, 1'b0);
    for (int i = 0; i < 3; i++) pulse(8'h04, 8'h00, 1'b0);
    rd(5'h04, v); chk("R9 count 3", v, 8'h30);
    wr(5'h04, 8'hFA);
    rd(5'h04, v); chk("R9 low nibble only", v, 8'h3A);
    chk("R9 ctl port", {4'd0, tx_mode_ctl}, 8'h0A);
    for (int i = 0; i < 20; i++) pulse(8'h04, 8'h00, 1'b0);
    rd(5'h04, v); chk("R9 saturate", v, 8'hFA);
    pulse(8'h84, 8'h00, 1'b0);
    rd(5'h04, v); chk("R9 ok clears", v, 8'h0A);
    clear_all();
  endtask

  task automatic t_read();
    logic [7:0] v;
    wr(5'h01, 8'h5C);
    rd(5'h01, v);
    rd(5'h1F, v); chk("R11 unmapped", v, 8'h00);
    rd(5'h01, v);
    wr(5'h01, 8'h00);
    pulse(8'hFF, 8'hFF, 1'b1);
    @(negedge clk);
    chk("R11 hold", reg_rdata, 8'h5C);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_latch();
    t_w1c();
    t_set_wins();
    t_masks();
    t_irq();
    t_dma();
    t_busy();
    t_coll();
    t_read();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule